// File: doc/BRIEF.md
# SIMT Branch Reconvergence Stack

This block keeps the per-thread activity of one warp of four lockstep threads while the warp runs through conditional branches. Every retired instruction is reported to it with an operation code. For a branch the report also carries one predicate bit per thread, the taken target, the next sequential PC (the fall-through path) and the PC at which the two paths join again. The block answers with the PC to fetch next and the mask of threads that execute it.

When the active threads disagree on a branch, the current top entry becomes the rejoin entry. It keeps the mask it had before the branch and has its PC moved to the join point. A fall-through entry and then a taken entry are pushed above it. The taken path runs first and the two paths run one after the other. Each path ends when its PC reaches the join point. The entry is then dropped, and the full pre-branch mask returns once both paths are gone. A thread that exits is removed from every stored mask. When the bottom mask becomes empty the warp has finished.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, pc_o is 0, active_mask_o is 0, stack_depth_o is 0, done_o is 1 and overflow_o is 0.
- R2: A launch pulse loads launch_pc_i and launch_mask_i into the bottom entry, sets the depth to 0 and clears overflow_o, all visible on the next cycle. Launch takes priority over any instruction reported in the same cycle.
- R3: A sequential instruction (instr_op_i = 0) moves pc_o to next_seq_pc_i on the next cycle and leaves the mask unchanged, unless that PC is the top entry's join point.
- R4: A branch (instr_op_i = 1) on which every active thread agrees leaves the depth unchanged. pc_o becomes target_pc_i if the agreed bit is 1 and next_seq_pc_i if it is 0. Predicate bit i belongs to thread i, and bits of inactive threads are ignored.
- R5: A divergent branch moves the current top entry's PC to reconv_pc_i and keeps its mask. It then pushes the fall-through entry (the not-taken threads) and, above it, the taken entry (the threads whose bit is 1). Next cycle the taken path is active and the depth has grown by 2.
- R6: On a divergent branch, a path whose start PC equals reconv_pc_i is not pushed.
- R7: When the top entry's PC equals its join point, that entry is dropped. If the entry then exposed is also at its own join point, it is dropped in the same cycle. Dropping back to a rejoin entry restores the exact pre-branch mask.
- R8: An exit instruction (instr_op_i = 2) removes the executing threads from every stored mask. Entries left empty are dropped, and the nearest non-empty entry below them resumes at its stored PC.
- R9: done_o is 1 exactly when the bottom mask is empty. Instructions reported while done_o is 1 are ignored.
- R10: A divergent branch that would need more entries than the stack holds sets overflow_o, which stays set until the next launch, and leaves the stack unchanged.
- R11: A cycle with instr_valid_i low, or with instr_op_i = 3, changes nothing.
- R12: With the default depth of 8, nesting divergent branches until a single thread remains reaches depth 6 without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Start the warp from launch_pc_i with launch_mask_i |
| launch_pc_i | input | PC_W | Start PC |
| launch_mask_i | input | WARP | Initial thread mask |
| instr_valid_i | input | 1 | An instruction at pc_o retired this cycle |
| instr_op_i | input | 2 | 0 sequential, 1 branch, 2 exit, 3 no effect |
| next_seq_pc_i | input | PC_W | Next sequential PC, also the branch fall-through PC |
| pred_i | input | WARP | Per-thread branch predicate, bit i for thread i |
| target_pc_i | input | PC_W | Branch taken target |
| reconv_pc_i | input | PC_W | Join point of the branch |
| pc_o | output | PC_W | PC to fetch next |
| active_mask_o | output | WARP | Threads that execute at pc_o |
| stack_depth_o | output | $clog2(DEPTH) | Index of the top entry |
| done_o | output | 1 | Warp finished or idle |
| overflow_o | output | 1 | Sticky: a divergent branch found the stack full |

## Verification
A corrupt stack entry stays hidden until it is uncovered, so the stimulus drives the warp through divergence, nesting, exits and rejoins. Every pop then brings a stored PC and mask out to pc_o and active_mask_o. A wrong push order shows up on the first cycle after the branch as the fall-through mask in place of the taken mask. A lost or stale mask shows up on the cycle after the pop that exposes it, either as a rejoin mask that differs from the pre-branch mask or as a finished warp whose done_o stays low. A wrong depth is visible on stack_depth_o in the same cycle as the error and decides whether a nested branch overflows.

// File: rtl/simt_rs_pkg.sv
package simt_rs_pkg;
  typedef enum logic [1:0] {
    OP_SEQ    = 2'd0,
    OP_BRANCH = 2'd1,
    OP_EXIT   = 2'd2,
    OP_NOP    = 2'd3
  } op_e;
endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval #(
  parameter int WARP = 4,
  parameter int PC_W = 16
) (
  input  logic [WARP-1:0] pred_i,
  input  logic [WARP-1:0] active_i,
  input  logic [PC_W-1:0] target_pc_i,
  input  logic [PC_W-1:0] fall_pc_i,
  input  logic [PC_W-1:0] reconv_pc_i,
  output logic [WARP-1:0] taken_o,
  output logic [WARP-1:0] fall_o,
  output logic            diverge_o,
  output logic [PC_W-1:0] uni_pc_o,
  output logic            push_fall_o,
  output logic            push_tgt_o
);
  always_comb begin
    taken_o     = pred_i & active_i;
    fall_o      = ~pred_i & active_i;
    diverge_o   = (|taken_o) && (|fall_o);
    uni_pc_o    = (|taken_o) ? target_pc_i : fall_pc_i;
    // a path that starts at the join point has nothing to run
    push_fall_o = (fall_pc_i != reconv_pc_i);
    push_tgt_o  = (target_pc_i != reconv_pc_i);
  end
endmodule

// File: rtl/simt_live_scan.sv
module simt_live_scan #(
  parameter int DEPTH = 8,
  parameter int WARP  = 4,
  parameter int PC_W  = 16,
  parameter int SP_W  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][PC_W-1:0] pc_i,
  input  logic [DEPTH-1:0][PC_W-1:0] rpc_i,
  input  logic [DEPTH-1:0][WARP-1:0] mask_i,
  input  logic [SP_W-1:0]            cand_i,
  output logic [SP_W-1:0]            sp_o
);
  logic [DEPTH-1:0] live;

  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    if (g == 0) begin : g_bot
      assign live[g] = |mask_i[g];
    end else begin : g_up
      assign live[g] = (|mask_i[g]) && (pc_i[g] != rpc_i[g]);
    end
  end

  // highest live entry at or below the candidate top
  always_comb begin
    sp_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live[i] && (i <= int'(cand_i))) sp_o = SP_W'(i);
    end
  end
endmodule

// File: rtl/simt_stack_regs.sv
module simt_stack_regs #(
  parameter int DEPTH = 8,
  parameter int WARP  = 4,
  parameter int PC_W  = 16,
  parameter int SP_W  = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       upd_i,
  input  logic [DEPTH-1:0][PC_W-1:0] pc_d_i,
  input  logic [DEPTH-1:0][PC_W-1:0] rpc_d_i,
  input  logic [DEPTH-1:0][WARP-1:0] mask_d_i,
  input  logic [SP_W-1:0]            sp_d_i,
  output logic [DEPTH-1:0][PC_W-1:0] pc_q_o,
  output logic [DEPTH-1:0][PC_W-1:0] rpc_q_o,
  output logic [DEPTH-1:0][WARP-1:0] mask_q_o,
  output logic [SP_W-1:0]            sp_q_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pc_q_o[g]   <= '0;
        rpc_q_o[g]  <= '0;
        mask_q_o[g] <= '0;
      end else if (upd_i) begin
        pc_q_o[g]   <= pc_d_i[g];
        rpc_q_o[g]  <= rpc_d_i[g];
        mask_q_o[g] <= mask_d_i[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q_o <= '0;
    else if (upd_i) sp_q_o <= sp_d_i;
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_rs_pkg::*;
#(
  parameter int WARP  = 4,
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            launch_i,
  input  logic [PC_W-1:0] launch_pc_i,
  input  logic [WARP-1:0] launch_mask_i,
  input  logic            instr_valid_i,
  input  logic [1:0]      instr_op_i,
  input  logic [PC_W-1:0] next_seq_pc_i,
  input  logic [WARP-1:0] pred_i,
  input  logic [PC_W-1:0] target_pc_i,
  input  logic [PC_W-1:0] reconv_pc_i,
  output logic [PC_W-1:0] pc_o,
  output logic [WARP-1:0] active_mask_o,
  output logic [SP_W-1:0] stack_depth_o,
  output logic            done_o,
  output logic            overflow_o
);
  logic [DEPTH-1:0][PC_W-1:0] pc_q, rpc_q, pc_n, rpc_n;
  logic [DEPTH-1:0][WARP-1:0] mask_q, mask_n;
  logic [SP_W-1:0]            sp_q, sp_n, cand, f_idx, t_idx;
  logic                       upd, ovf_hit, ovf_q, go;
  logic [WARP-1:0]            top_mask, taken, fallm;
  logic [PC_W-1:0]            uni_pc;
  logic                       diverge, push_f, push_t, room_ok;
  op_e                        op;

  assign op       = op_e'(instr_op_i);
  assign top_mask = mask_q[sp_q];
  assign done_o   = ~|mask_q[0];
  assign go       = instr_valid_i && !done_o;

  simt_branch_eval #(.WARP(WARP), .PC_W(PC_W)) u_eval (
    .pred_i      (pred_i),
    .active_i    (top_mask),
    .target_pc_i (target_pc_i),
    .fall_pc_i   (next_seq_pc_i),
    .reconv_pc_i (reconv_pc_i),
    .taken_o     (taken),
    .fall_o      (fallm),
    .diverge_o   (diverge),
    .uni_pc_o    (uni_pc),
    .push_fall_o (push_f),
    .push_tgt_o  (push_t)
  );

  assign room_ok = (int'(sp_q) + int'(push_f) + int'(push_t)) <= (DEPTH - 1);
  assign f_idx   = sp_q + SP_W'(1);
  assign t_idx   = sp_q + SP_W'(1) + SP_W'(push_f);

  always_comb begin
    pc_n    = pc_q;
    rpc_n   = rpc_q;
    mask_n  = mask_q;
    cand    = sp_q;
    upd     = 1'b0;
    ovf_hit = 1'b0;
    if (launch_i) begin
      pc_n[0]   = launch_pc_i;
      rpc_n[0]  = '0;
      mask_n[0] = launch_mask_i;
      cand      = '0;
      upd       = 1'b1;
    end else if (go) begin
      unique case (op)
        OP_SEQ: begin
          pc_n[sp_q] = next_seq_pc_i;
          upd        = 1'b1;
        end
        OP_BRANCH: begin
          if (!diverge) begin
            pc_n[sp_q] = uni_pc;
            upd        = 1'b1;
          end else if (room_ok) begin
            // top becomes the rejoin entry; fall-through below taken
            pc_n[sp_q] = reconv_pc_i;
            if (push_f) begin
              pc_n[f_idx]   = next_seq_pc_i;
              rpc_n[f_idx]  = reconv_pc_i;
              mask_n[f_idx] = fallm;
            end
            if (push_t) begin
              pc_n[t_idx]   = target_pc_i;
              rpc_n[t_idx]  = reconv_pc_i;
              mask_n[t_idx] = taken;
            end
            cand = sp_q + SP_W'(push_f) + SP_W'(push_t);
            upd  = 1'b1;
          end else begin
            ovf_hit = 1'b1;
          end
        end
        OP_EXIT: begin
          for (int i = 0; i < DEPTH; i++) mask_n[i] = mask_q[i] & ~top_mask;
          upd = 1'b1;
        end
        default: ;
      endcase
    end
  end

  simt_live_scan #(.DEPTH(DEPTH), .WARP(WARP), .PC_W(PC_W), .SP_W(SP_W)) u_scan (
    .pc_i   (pc_n),
    .rpc_i  (rpc_n),
    .mask_i (mask_n),
    .cand_i (cand),
    .sp_o   (sp_n)
  );

  simt_stack_regs #(.DEPTH(DEPTH), .WARP(WARP), .PC_W(PC_W), .SP_W(SP_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .pc_d_i   (pc_n),
    .rpc_d_i  (rpc_n),
    .mask_d_i (mask_n),
    .sp_d_i   (sp_n),
    .pc_q_o   (pc_q),
    .rpc_q_o  (rpc_q),
    .mask_q_o (mask_q),
    .sp_q_o   (sp_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovf_q <= 1'b0;
    else if (launch_i) ovf_q <= 1'b0;
    else if (ovf_hit)  ovf_q <= 1'b1;
  end

  assign pc_o          = pc_q[sp_q];
  assign active_mask_o = top_mask;
  assign stack_depth_o = sp_q;
  assign overflow_o    = ovf_q;
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int WARP  = 4,
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  localparam int SP_W = $clog2(DEPTH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            launch_i,
  input logic [PC_W-1:0] launch_pc_i,
  input logic [WARP-1:0] launch_mask_i,
  input logic            instr_valid_i,
  input logic [1:0]      instr_op_i,
  input logic [PC_W-1:0] next_seq_pc_i,
  input logic [WARP-1:0] pred_i,
  input logic [PC_W-1:0] target_pc_i,
  input logic [PC_W-1:0] reconv_pc_i,
  input logic [PC_W-1:0] pc_o,
  input logic [WARP-1:0] active_mask_o,
  input logic [SP_W-1:0] stack_depth_o,
  input logic            done_o,
  input logic            overflow_o
);
  p_launch_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> (pc_o == $past(launch_pc_i)) && (active_mask_o == $past(launch_mask_i))
                 && (stack_depth_o == '0) && !overflow_o);

  p_seq_depth0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_i && instr_valid_i && instr_op_i == 2'd0 && !done_o && stack_depth_o == '0)
    |=> (pc_o == $past(next_seq_pc_i)) && (active_mask_o == $past(active_mask_o)));

  p_diverge_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_i && instr_valid_i && instr_op_i == 2'd1 && !done_o
     && (|(pred_i & active_mask_o)) && (|(~pred_i & active_mask_o))
     && target_pc_i != reconv_pc_i)
    |=> overflow_o || (active_mask_o == $past(pred_i & active_mask_o)));

  p_depth_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> int'(stack_depth_o) <= int'($past(stack_depth_o)) + 2);

  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !launch_i) |=> done_o && $stable(pc_o) && (active_mask_o == '0));

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !launch_i) |=> overflow_o);

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch_i && (!instr_valid_i || instr_op_i == 2'd3))
    |=> $stable(pc_o) && $stable(active_mask_o) && $stable(stack_depth_o));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
  .WARP(WARP), .DEPTH(DEPTH), .PC_W(PC_W)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .launch_i      (launch_i),
  .launch_pc_i   (launch_pc_i),
  .launch_mask_i (launch_mask_i),
  .instr_valid_i (instr_valid_i),
  .instr_op_i    (instr_op_i),
  .next_seq_pc_i (next_seq_pc_i),
  .pred_i        (pred_i),
  .target_pc_i   (target_pc_i),
  .reconv_pc_i   (reconv_pc_i),
  .pc_o          (pc_o),
  .active_mask_o (active_mask_o),
  .stack_depth_o (stack_depth_o),
  .done_o        (done_o),
  .overflow_o    (overflow_o)
);

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb_top;
  localparam int WARP = 4;
  localparam int PC_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            launch = 1'b0;
  logic [PC_W-1:0] launch_pc = '0;
  logic [WARP-1:0] launch_mask = '0;
  logic            ivalid = 1'b0;
  logic [1:0]      op = 2'd0;
  logic [PC_W-1:0] seq_pc = '0, tgt_pc = '0, rc_pc = '0;
  logic [WARP-1:0] pred = '0;

  logic [PC_W-1:0] pc, pc_s;
  logic [WARP-1:0] mask, mask_s;
  logic [2:0]      depth;
  logic [1:0]      depth_s;
  logic            done, done_s, ovf, ovf_s;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  simt_reconv_stack dut_i (
    .clk_i(clk), .rst_ni(rst_n), .launch_i(launch), .launch_pc_i(launch_pc),
    .launch_mask_i(launch_mask), .instr_valid_i(ivalid), .instr_op_i(op),
    .next_seq_pc_i(seq_pc), .pred_i(pred), .target_pc_i(tgt_pc), .reconv_pc_i(rc_pc),
    .pc_o(pc), .active_mask_o(mask), .stack_depth_o(depth), .done_o(done), .overflow_o(ovf)
  );

  simt_reconv_stack #(.DEPTH(4)) small_i (
    .clk_i(clk), .rst_ni(rst_n), .launch_i(launch), .launch_pc_i(launch_pc),
    .launch_mask_i(launch_mask), .instr_valid_i(ivalid), .instr_op_i(op),
    .next_seq_pc_i(seq_pc), .pred_i(pred), .target_pc_i(tgt_pc), .reconv_pc_i(rc_pc),
    .pc_o(pc_s), .active_mask_o(mask_s), .stack_depth_o(depth_s), .done_o(done_s),
    .overflow_o(ovf_s)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int e_pc, input int e_mask, input int e_depth);
    chk(req, "pc", int'(pc), e_pc);
    chk(req, "mask", int'(mask), e_mask);
    chk(req, "depth", int'(depth), e_depth);
  endtask

  task automatic do_launch(input logic [PC_W-1:0] p, input logic [WARP-1:0] m);
    @(negedge clk);
    launch = 1'b1; launch_pc = p; launch_mask = m;
    @(posedge clk); #1;
    launch = 1'b0;
  endtask

  task automatic step(input logic [1:0] o, input logic [PC_W-1:0] s,
                      input logic [WARP-1:0] pr, input logic [PC_W-1:0] t,
                      input logic [PC_W-1:0] r);
    @(negedge clk);
    ivalid = 1'b1; op = o; seq_pc = s; pred = pr; tgt_pc = t; rc_pc = r;
    @(posedge clk); #1;
    ivalid = 1'b0;
  endtask

  task automatic t_reset();
    chk_state("R1", 0, 0, 0);
    chk("R1", "done", int'(done), 1);
    chk("R1", "overflow", int'(ovf), 0);
  endtask

  task automatic t_launch_seq();
    do_launch(16'h10, 4'hF);
    chk_state("R2", 'h10, 'hF, 0);
    chk("R2", "done", int'(done), 0);
    step(2'd0, 16'h11, 4'h0, 16'h0, 16'h0);
    chk_state("R3", 'h11, 'hF, 0);
  endtask

  task automatic t_idle();
    do_launch(16'h10, 4'hF);
    @(negedge clk); @(posedge clk); #1;
    chk_state("R11", 'h10, 'hF, 0);
    step(2'd3, 16'h77, 4'h5, 16'h66, 16'h55);
    chk_state("R11", 'h10, 'hF, 0);
  endtask

  task automatic t_uniform();
    do_launch(16'h10, 4'hF);
    step(2'd1, 16'h11, 4'hF, 16'h40, 16'h50);
    chk_state("R4", 'h40, 'hF, 0);
    step(2'd1, 16'h41, 4'h0, 16'h60, 16'h70);
    chk_state("R4", 'h41, 'hF, 0);
  endtask

  // nested narrowing 4 -> 2 -> 1 threads with a shared join point
  task automatic t_nested_shared();
    do_launch(16'h10, 4'hF);
    step(2'd1, 16'h11, 4'b1100, 16'h20, 16'h20);
    chk_state("R6", 'h11, 'b0011, 1);
    step(2'd0, 16'h12, 4'h0, 16'h0, 16'h0);
    chk_state("R3", 'h12, 'b0011, 1);
    step(2'd1, 16'h13, 4'b1110, 16'h20, 16'h20);
    chk_state("R6", 'h13, 'b0001, 2);
    step(2'd0, 16'h20, 4'h0, 16'h0, 16'h0);
    chk_state("R7", 'h20, 'hF, 0);
    step(2'd2, 16'h0, 4'h0, 16'h0, 16'h0);
    chk("R9", "done", int'(done), 1);
    chk("R9", "mask", int'(mask), 0);
    step(2'd0, 16'h55, 4'h0, 16'h0, 16'h0);
    chk("R9", "pc ignored", int'(pc), 'h20);
    chk("R9", "done held", int'(done), 1);
  endtask

  task automatic t_if_else();
    do_launch(16'h100, 4'hF);
    step(2'd1, 16'h101, 4'b0101, 16'h200, 16'h300);
    chk_state("R5", 'h200, 'b0101, 2);
    step(2'd1, 16'h201, 4'b1010, 16'h260, 16'h280);
    chk_state("R4", 'h201, 'b0101, 2);
    step(2'd0, 16'h300, 4'h0, 16'h0, 16'h0);
    chk_state("R7", 'h101, 'b1010, 1);
    step(2'd0, 16'h300, 4'h0, 16'h0, 16'h0);
    chk_state("R7", 'h300, 'hF, 0);
  endtask

  task automatic t_exit_path();
    do_launch(16'h10, 4'hF);
    step(2'd1, 16'h11, 4'b0011, 16'h20, 16'h30);
    chk_state("R5", 'h20, 'b0011, 2);
    step(2'd2, 16'h0, 4'h0, 16'h0, 16'h0);
    chk_state("R8", 'h11, 'b1100, 1);
    step(2'd0, 16'h30, 4'h0, 16'h0, 16'h0);
    chk_state("R7", 'h30, 'b1100, 0);
    chk("R9", "done before exit", int'(done), 0);
    step(2'd2, 16'h0, 4'h0, 16'h0, 16'h0);
    chk("R9", "done", int'(done), 1);
  endtask

  task automatic t_exit_frame();
    do_launch(16'h10, 4'hF);
    step(2'd1, 16'h11, 4'b0011, 16'h20, 16'h30);
    step(2'd1, 16'h21, 4'b0001, 16'h40, 16'h50);
    chk_state("R5", 'h40, 'b0001, 4);
    step(2'd2, 16'h0, 4'h0, 16'h0, 16'h0);
    chk_state("R8", 'h21, 'b0010, 3);
    step(2'd2, 16'h0, 4'h0, 16'h0, 16'h0);
    chk_state("R8", 'h11, 'b1100, 1);
    step(2'd0, 16'h30, 4'h0, 16'h0, 16'h0);
    chk_state("R8", 'h30, 'b1100, 0);
  endtask

  task automatic t_deep_overflow();
    do_launch(16'h10, 4'hF);
    step(2'd1, 16'h11, 4'b1110, 16'h20, 16'h90);
    step(2'd1, 16'h21, 4'b1100, 16'h30, 16'h80);
    chk("R10", "overflow set", int'(ovf_s), 1);
    chk("R10", "small pc unchanged", int'(pc_s), 'h20);
    chk("R10", "small mask unchanged", int'(mask_s), 'b1110);
    chk("R10", "small depth unchanged", int'(depth_s), 2);
    step(2'd1, 16'h31, 4'b1000, 16'h40, 16'h70);
    chk_state("R12", 'h40, 'b1000, 6);
    chk("R12", "no overflow", int'(ovf), 0);
    chk("R10", "overflow sticky", int'(ovf_s), 1);
    step(2'd0, 16'h70, 4'h0, 16'h0, 16'h0);
    chk_state("R7", 'h31, 'b0100, 5);
    step(2'd0, 16'h70, 4'h0, 16'h0, 16'h0);
    chk_state("R7", 'h70, 'b1100, 4);
    do_launch(16'h10, 4'hF);
    chk("R2", "overflow cleared", int'(ovf_s), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_launch_seq();
    t_idle();
    t_uniform();
    t_nested_shared();
    t_if_else();
    t_exit_path();
    t_exit_frame();
    t_deep_overflow();
    finish_run();
  end
endmodule